// File: doc/BRIEF.md
# EEE Low-Power-Idle Transmit Controller

This block decides when the transmit side of an Ethernet MAC may drop into the Energy Efficient Ethernet low-power-idle (LPI) state, and when it must leave it. Software programs a small register set: a control word with enable, automatic-transmit, clock-gating and link-good bits, and a timer word that holds a link-stable time in milliseconds and a wake time in microseconds. A free-running prescaler makes a microsecond tick from the system clock, and a divider makes a millisecond tick from that.

Once LPI is wanted and the link is reported good, the controller waits for the link-stable time and then asserts the LPI indication towards the PHY-side logic. A transmit request, loss of the link bit, or clearing either enable bit ends LPI. The controller then holds a wake indication for the programmed wake time before normal transmission resumes. Four sticky flags record transmit entry and exit and receive-side entry and exit. They clear when the status word is read. A masked interrupt is raised from them.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, every output is low and every register reads back as zero.
- R2: Register addresses are: 0 control, 1 timer, 2 status, 3 interrupt mask. Control bits are 0 LPI enable, 1 automatic transmit, 2 clock-gate enable and 3 link good. The timer holds the wake time in bits 15:0 and the link-stable time in bits 25:16, and bits 31:26 read as zero. The mask uses bits 3:0. Read data appears on `rd_data` one clock after the `rd_en` cycle.
- R3: With enable, automatic transmit and link good all set and no transmit request, `tx_lpi_o` rises exactly LS*CLK_PER_US*US_PER_MS+2 clock edges after the edge that writes the control word, where LS is the link-stable field.
- R4: LPI is never entered while link good, LPI enable or automatic transmit is clear. Clearing any of them while in LPI ends LPI within two edges of the write.
- R5: A transmit request while in LPI drops `tx_lpi_o` and raises `tx_wake_o` at the next edge.
- R6: `tx_wake_o` stays high for TW*CLK_PER_US+1 cycles, where TW is the wake-time field, and a transmit request held during that time does not shorten it.
- R7: `tx_clk_gate_o` is high only while `tx_lpi_o` is high and the clock-gate enable bit is set.
- R8: Status bits are sticky. Bit 0 marks transmit LPI entry, bit 1 transmit LPI exit, bit 2 a rising edge of `rx_lpi_detect`, and bit 3 a falling edge of `rx_lpi_detect`.
- R9: A read of the status word returns its value and clears it. An event that occurs in the same cycle as the read is not lost and appears in the next read.
- R10: `irq_o` is high exactly when some status bit is set whose mask bit is set. It follows status and mask writes at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| tx_req | input | 1 | MAC has a frame to send |
| rx_lpi_detect | input | 1 | Receive side currently sees LPI |
| tx_lpi_o | output | 1 | Assert the LPI pattern on transmit |
| tx_wake_o | output | 1 | Wake time running; transmit still held off |
| tx_clk_gate_o | output | 1 | Transmit clock may be stopped |
| irq_o | output | 1 | Masked status interrupt |

## Verification
Two functions can act on the same cycle: the clear-on-read of the status word, and the setting of a status flag by an event. The bench provokes this by issuing a status read in the very cycle where `rx_lpi_detect` rises. It then judges the result: the returned word must lack the new bit, and the following read must hold it. Timing is swept over several link-stable and wake values, and the entry and wake delays are compared with figures the bench computes arithmetically.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WAIT_LS = 2'd1,
    ST_LPI     = 2'd2,
    ST_WAKE    = 2'd3
  } lpi_state_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_TIMER  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_MASK   = 2'd3;

  localparam int NUM_FLAGS = 4;

  // bit 3 link good, bit 2 clock gate, bit 1 auto transmit, bit 0 enable
  typedef struct packed {
    logic link_up;
    logic gate_en;
    logic tx_auto;
    logic lpi_en;
  } ctrl_t;

endpackage

// File: rtl/eee_tick_gen.sv
module eee_tick_gen #(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic us_tick,
  output logic ms_tick
);
  localparam int PS_W = $clog2(CLK_PER_US + 1);
  localparam int MS_W = $clog2(US_PER_MS + 1);

  logic [PS_W-1:0] ps_q;
  logic [MS_W-1:0] ms_q;

  assign us_tick = (ps_q == PS_W'(CLK_PER_US - 1));
  assign ms_tick = us_tick && (ms_q == MS_W'(US_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ps_q <= '0;
      ms_q <= '0;
    end else begin
      ps_q <= us_tick ? '0 : ps_q + 1'b1;
      if (us_tick) ms_q <= ms_tick ? '0 : ms_q + 1'b1;
    end
  end
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_lpi_pkg::*;
#(
  parameter int LS_W = 10,
  parameter int TW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  logic [LS_W-1:0] ls,
  input  logic [TW_W-1:0] tw,
  input  logic            tx_req,
  input  logic            us_tick,
  input  logic            ms_tick,
  output logic            tick_clr,
  output logic            ev_entry,
  output logic            ev_exit,
  output logic            tx_lpi_o,
  output logic            tx_wake_o,
  output logic            tx_gate_o
);
  localparam int CNT_W = (TW_W > LS_W) ? TW_W : LS_W;

  lpi_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             want_lpi, ls_done, tw_done, cnt_step;

  assign want_lpi = ctrl.lpi_en & ctrl.tx_auto & ctrl.link_up;
  assign ls_done  = (cnt_q >= CNT_W'(ls));
  assign tw_done  = (cnt_q >= CNT_W'(tw));
  assign tick_clr = (state_q == ST_ACTIVE) || (state_q == ST_LPI);
  assign cnt_step = ((state_q == ST_WAIT_LS) && ms_tick) ||
                    ((state_q == ST_WAKE) && us_tick);

  always_comb begin
    state_d  = state_q;
    ev_entry = 1'b0;
    ev_exit  = 1'b0;
    case (state_q)
      ST_ACTIVE:  if (want_lpi) state_d = ST_WAIT_LS;
      ST_WAIT_LS: begin
        if (!want_lpi) state_d = ST_ACTIVE;
        else if (ls_done && !tx_req) begin
          state_d  = ST_LPI;
          ev_entry = 1'b1;
        end
      end
      ST_LPI: begin
        if (tx_req || !want_lpi) begin
          state_d = ST_WAKE;
          ev_exit = 1'b1;
        end
      end
      ST_WAKE:    if (tw_done) state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACTIVE;
      cnt_q     <= '0;
      tx_lpi_o  <= 1'b0;
      tx_wake_o <= 1'b0;
      tx_gate_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (tick_clr) cnt_q <= '0;
      else if (cnt_step && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
      tx_lpi_o  <= (state_d == ST_LPI);
      tx_wake_o <= (state_d == ST_WAKE);
      tx_gate_o <= (state_d == ST_LPI) && ctrl.gate_en;
    end
  end
endmodule

// File: rtl/eee_lpi_regs.sv
module eee_lpi_regs
  import eee_lpi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LS_W   = 10,
  parameter int TW_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [1:0]           rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 ev_entry,
  input  logic                 ev_exit,
  input  logic                 rx_lpi_detect,
  output ctrl_t                ctrl_o,
  output logic [LS_W-1:0]      ls_o,
  output logic [TW_W-1:0]      tw_o,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic [NUM_FLAGS-1:0] mask_o,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic                 irq_o
);
  localparam int TIMER_W = TW_W + LS_W;

  logic [NUM_FLAGS-1:0] status_d, mask_d;
  logic                 rx_prev_q, rd_clr;
  logic [DATA_W-TIMER_W-1:0] unused_wdata;

  assign unused_wdata = wr_data[DATA_W-1:TIMER_W];
  assign rd_clr = rd_en && (rd_addr == ADDR_STATUS);
  assign set_o  = {~rx_lpi_detect & rx_prev_q, rx_lpi_detect & ~rx_prev_q,
                   ev_exit, ev_entry};
  assign mask_d = (wr_en && wr_addr == ADDR_MASK) ? wr_data[NUM_FLAGS-1:0] : mask_o;

  for (genvar b = 0; b < NUM_FLAGS; b++) begin : g_flag
    assign status_d[b] = (status_o[b] & ~rd_clr) | set_o[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o    <= '0;
      ls_o      <= '0;
      tw_o      <= '0;
      status_o  <= '0;
      mask_o    <= '0;
      irq_o     <= 1'b0;
      rx_prev_q <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_CTRL)  ctrl_o <= ctrl_t'(wr_data[3:0]);
      if (wr_en && wr_addr == ADDR_TIMER) begin
        tw_o <= wr_data[TW_W-1:0];
        ls_o <= wr_data[TW_W +: LS_W];
      end
      mask_o    <= mask_d;
      status_o  <= status_d;
      irq_o     <= |(status_d & mask_d);
      rx_prev_q <= rx_lpi_detect;
      if (rd_en) begin
        case (rd_addr)
          ADDR_CTRL:   rd_data <= DATA_W'(ctrl_o);
          ADDR_TIMER:  rd_data <= DATA_W'({ls_o, tw_o});
          ADDR_STATUS: rd_data <= DATA_W'(status_o);
          ADDR_MASK:   rd_data <= DATA_W'(mask_o);
          default:     rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LS_W       = 10,
  parameter int TW_W       = 16,
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_req,
  input  logic              rx_lpi_detect,
  output logic              tx_lpi_o,
  output logic              tx_wake_o,
  output logic              tx_clk_gate_o,
  output logic              irq_o
);
  ctrl_t                ctrl_w;
  logic [LS_W-1:0]      ls_w;
  logic [TW_W-1:0]      tw_w;
  logic [NUM_FLAGS-1:0] status_w, mask_w, set_w;
  logic                 us_tick, ms_tick, tick_clr, ev_entry, ev_exit;

  eee_tick_gen #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .clr(tick_clr), .us_tick(us_tick), .ms_tick(ms_tick)
  );

  eee_lpi_fsm #(.LS_W(LS_W), .TW_W(TW_W)) u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl_w), .ls(ls_w), .tw(tw_w), .tx_req(tx_req),
    .us_tick(us_tick), .ms_tick(ms_tick), .tick_clr(tick_clr),
    .ev_entry(ev_entry), .ev_exit(ev_exit), .tx_lpi_o(tx_lpi_o),
    .tx_wake_o(tx_wake_o), .tx_gate_o(tx_clk_gate_o)
  );

  eee_lpi_regs #(.DATA_W(DATA_W), .LS_W(LS_W), .TW_W(TW_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_entry(ev_entry), .ev_exit(ev_exit), .rx_lpi_detect(rx_lpi_detect),
    .ctrl_o(ctrl_w), .ls_o(ls_w), .tw_o(tw_w), .status_o(status_w),
    .mask_o(mask_w), .set_o(set_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk
  import eee_lpi_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic [1:0]           rd_addr,
  input logic                 tx_lpi,
  input logic                 tx_wake,
  input logic                 tx_gate,
  input logic                 irq,
  input ctrl_t                ctrl,
  input logic [NUM_FLAGS-1:0] status,
  input logic [NUM_FLAGS-1:0] mask,
  input logic [NUM_FLAGS-1:0] set_ev
);
  AST_ENTRY_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_lpi) |-> $past(ctrl.link_up && ctrl.lpi_en && ctrl.tx_auto)); // R3
  AST_LINK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.link_up && !tx_lpi) |=> !tx_lpi); // R4
  AST_EXIT_TO_WAKE: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_lpi) |-> tx_wake); // R5
  AST_WAKE_NOT_LPI: assert property (@(posedge clk) disable iff (rst)
    !(tx_lpi && tx_wake)); // R6
  AST_GATE_ONLY_LPI: assert property (@(posedge clk) disable iff (rst)
    tx_gate |-> tx_lpi); // R7
  AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_lpi) |-> status[0]); // R8
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && ($past(rd_addr) == ADDR_STATUS) && ($past(set_ev) == '0))
    |-> (status == '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(status & mask)); // R10
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .tx_lpi(tx_lpi_o), .tx_wake(tx_wake_o), .tx_gate(tx_clk_gate_o), .irq(irq_o),
  .ctrl(ctrl_w), .status(status_w), .mask(mask_w), .set_ev(set_w)
);

// File: tb/eee_lpi_ctrl_tb_top.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_tb_top;
  localparam int CP = 2;
  localparam int UM = 4;
  localparam int K  = CP * UM;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, tx_req = 1'b0, rx_det = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tx_lpi, tx_wake, tx_gate, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  eee_lpi_ctrl #(.CLK_PER_US(CP), .US_PER_MS(UM)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tx_req(tx_req),
    .rx_lpi_detect(rx_det), .tx_lpi_o(tx_lpi), .tx_wake_o(tx_wake),
    .tx_clk_gate_o(tx_gate), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outputs", {28'd0, tx_lpi, tx_wake, tx_gate, irq}, 32'd0);
    rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
    rd(2'd1, d); chk("R1 timer", d, 32'd0);
    rd(2'd2, d); chk("R1 status", d, 32'd0);
    rd(2'd3, d); chk("R1 mask", d, 32'd0);

    // R2 register layout and read-back
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 timer width", d, 32'h03FF_FFFF);
    wr(2'd1, (32'd3 << 16) | 32'd5); rd(2'd1, d); chk("R2 timer fields", d, 32'h0003_0005);
    wr(2'd3, 32'hFFFF_FFF5); rd(2'd3, d); chk("R2 mask", d, 32'h5);
    wr(2'd0, 32'hFFFF_FFF2); rd(2'd0, d); chk("R2 ctrl", d, 32'h2);
    wr(2'd0, 32'h0); wr(2'd3, 32'h0);

    // R3 R5 R6 R7 R8 sweep of link-stable and wake times
    for (int ls = 0; ls < 4; ls++) begin
      for (int ti = 0; ti < 3; ti++) begin
        int tw;
        logic g;
        tw = (ti == 0) ? 0 : (ti == 1) ? 1 : 3;
        g  = ls[0];
        rd(2'd2, d);
        wr(2'd1, (32'(ls) << 16) | 32'(tw));
        wr(2'd0, 32'hB | (32'(g) << 2));
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (!tx_lpi && n < 2000);
        chk("R3 entry delay", 32'(n), 32'(ls * K + 2));
        chk("R7 gate in lpi", {31'd0, tx_gate}, {31'd0, g});
        rd(2'd2, d); chk("R8 entry flag", d, 32'h1);
        tx_req = 1'b1;
        @(negedge clk);
        chk("R5 exit on request", {30'd0, tx_lpi, tx_wake}, 32'h1);
        n = 1;
        while (tx_wake && n < 2000) begin @(posedge clk); n++; @(negedge clk); end
        chk("R6 wake length", 32'(n), 32'(tw * CP + 2));
        wr(2'd0, 32'h0);
        tx_req = 1'b0;
        idle(2);
        rd(2'd2, d); chk("R8 exit flag", d, 32'h2);
      end
    end

    // R4 entry blocked without link or without automatic transmit
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h3); idle(40);
    chk("R4 no link", {31'd0, tx_lpi}, 32'd0);
    wr(2'd0, 32'h9); idle(40);
    chk("R4 no auto", {31'd0, tx_lpi}, 32'd0);
    rd(2'd2, d); chk("R4 no flags", d, 32'h0);
    wr(2'd0, 32'hB); idle(4);
    chk("R4 enters with all set", {31'd0, tx_lpi}, 32'd1);
    wr(2'd0, 32'h3); idle(1);
    chk("R4 link drop exits", {31'd0, tx_lpi}, 32'd0);
    wr(2'd0, 32'h0); idle(4);
    rd(2'd2, d); chk("R8 flags after link drop", d, 32'h3);

    // R9 read and event in the same cycle
    @(negedge clk); rd_en = 1'b1; rd_addr = 2'd2; rx_det = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R9 collide read value", rd_data, 32'h0);
    rd(2'd2, d); chk("R9 event kept", d, 32'h4);
    rx_det = 1'b0; idle(2);
    rd(2'd2, d); chk("R8 rx exit flag", d, 32'h8);
    rd(2'd2, d); chk("R9 cleared", d, 32'h0);

    // R10 interrupt masking
    rx_det = 1'b1; idle(3);
    chk("R10 masked off", {31'd0, irq}, 32'd0);
    wr(2'd3, 32'h4);
    chk("R10 mask write raises", {31'd0, irq}, 32'd1);
    rd(2'd2, d);
    chk("R10 read clears irq", {31'd0, irq}, 32'd0);
    wr(2'd3, 32'h1);
    rx_det = 1'b0; idle(3);
    chk("R10 other bit masked", {31'd0, irq}, 32'd0);
    wr(2'd3, 32'h8);
    chk("R10 exit bit enabled", {31'd0, irq}, 32'd1);
    rd(2'd2, d); wr(2'd3, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule